// File: doc/BRIEF.md
# External Interrupt Edge/Level Detector

This block turns four external interrupt pins and one non-maskable interrupt pin into sticky request flags. Software sets the trigger condition through a write-only mode register. Each maskable pin can be set to detect rising or falling edges. Pin 0 can instead be set to detect a high level. The non-maskable pin triggers either on falling edges only or on both edges.

A pending flag is cleared by writing that source's vector code to a separate write-only clear register. No bit mask is used. The pins arrive already synchronized to `clk`. The register port is a plain single-cycle write strobe with address and data. Priority arbitration and vector delivery to the processor happen elsewhere; this block only produces the flags.

Edge detection compares each pin sample with the sample taken one clock earlier. The stored samples reset to the inactive level, so leaving reset does not create an edge.

Top module: `eirq_detector`

## Requirements
- R1: While `rst` is high, every request flag is 0 after the next clock edge. The mode register resets to 0: all pins use rising edges, pin 0 uses edge mode, and the non-maskable pin uses falling edges only.
- R2: A write to address 0x8C loads the mode register from data bits 5:0, and the new mode applies from the following cycle. Bit 0 selects the non-maskable trigger. Bit 1 selects pin 0 level mode. Bits 2 to 5 select the edge polarity of pins 0 to 3. Data bits 7:6 and writes to any other address leave the mode unchanged.
- R3: When a pin's polarity bit is 0, a low-to-high change between two consecutive samples sets that pin's flag one cycle later. A falling change does not set it.
- R4: When a pin's polarity bit is 1, a high-to-low change sets that pin's flag one cycle later. A rising change does not set it.
- R5: With mode bit 1 at 1, pin 0's flag is set in every cycle that follows a cycle in which pin 0 is high. A clear written while pin 0 is high has no lasting effect. After pin 0 goes low, the flag stays pending until it is cleared.
- R6: With mode bit 0 at 0, only a high-to-low change on the non-maskable pin sets its flag. With mode bit 0 at 1, a change in either direction sets it.
- R7: A write to address 0x88 clears exactly one flag, chosen by data bits 5:0: 0x0A clears pin 0, 0x0B pin 1, 0x0C pin 2, 0x0D pin 3, and 0x02 the non-maskable flag. Data bits 7:6 are ignored. Any other code clears nothing. A flag falls only after such a write.
- R8: If a set condition and a matching clear write occur in the same cycle, the flag is 1 afterwards.
- R9: A set flag stays set until a matching clear write, whatever the pins do.
- R10: With pins low and the non-maskable pin high during and after reset, no flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NUM_PINS | Synchronized maskable interrupt pins |
| nmi_i | input | 1 | Synchronized non-maskable interrupt pin |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | DATA_W | Register write data |
| req_o | output | NUM_PINS | Pending request flags of the maskable pins |
| nmi_req_o | output | 1 | Pending request flag of the non-maskable pin |

## Verification
The assertions assume that `pin_i` and `nmi_i` are already synchronous to `clk` and change at most once per cycle. They also assume that a write is a single-cycle strobe with address and data valid together. The bench changes every input on the falling clock edge only, so each value is stable across the rising edge that samples it. The bench holds the non-maskable pin high through reset, so that pin starts at its inactive level. The random phase draws pin values, mode bytes (including set upper bits) and clear codes (including codes that match no source) under these same rules.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

    localparam int VEC_W = 6;

    typedef enum logic [1:0] {
        TRIG_RISE = 2'd0,
        TRIG_FALL = 2'd1,
        TRIG_HIGH = 2'd2
    } trig_e;

    typedef struct packed {
        logic             mode_we;
        logic             clr_we;
        logic [VEC_W-1:0] code;
    } wr_req_t;

    function automatic trig_e trig_of(input logic fall, input logic level);
        if (level)
            return TRIG_HIGH;
        else if (fall)
            return TRIG_FALL;
        return TRIG_RISE;
    endfunction

    function automatic logic trig_hit(input trig_e t, input logic prev, input logic cur);
        case (t)
            TRIG_HIGH: return cur;
            TRIG_FALL: return prev & ~cur;
            default:   return ~prev & cur;
        endcase
    endfunction

    function automatic logic nmi_hit(input logic both, input logic prev, input logic cur);
        return (prev & ~cur) | (both & ~prev & cur);
    endfunction

endpackage

// File: rtl/eirq_cfg.sv
module eirq_cfg
    import eirq_pkg::*;
#(
    parameter int              NUM_PINS  = 4,
    parameter int              ADDR_W    = 8,
    parameter int              DATA_W    = 8,
    parameter logic [ADDR_W-1:0] MODE_ADDR = 8'h8C,
    parameter logic [ADDR_W-1:0] CLR_ADDR  = 8'h88,
    parameter logic [VEC_W-1:0]  VEC_BASE  = 6'h0A,
    parameter logic [VEC_W-1:0]  NMI_VEC   = 6'h02
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en_i,
    input  logic [ADDR_W-1:0]     wr_addr_i,
    input  logic [DATA_W-1:0]     wr_data_i,
    output trig_e [NUM_PINS-1:0]  trig_o,
    output logic                  nmi_both_o,
    output logic [NUM_PINS-1:0]   pin_clr_o,
    output logic                  nmi_clr_o
);

    localparam int MODE_W  = NUM_PINS + 2;
    localparam int POL_LSB = 2;

    wr_req_t           req;
    logic [MODE_W-1:0] mode_q;
    logic              unused_hi_bits;

    assign unused_hi_bits = ^wr_data_i[DATA_W-1:MODE_W];

    always_comb begin
        req.mode_we = wr_en_i && (wr_addr_i == MODE_ADDR);
        req.clr_we  = wr_en_i && (wr_addr_i == CLR_ADDR);
        req.code    = wr_data_i[VEC_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= '0;
        else if (req.mode_we)
            mode_q <= wr_data_i[MODE_W-1:0];
    end

    assign nmi_both_o = mode_q[0];

    for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
        localparam logic [VEC_W-1:0] PIN_VEC = VEC_W'(int'(VEC_BASE) + k);
        if (k == 0) begin : g_lvl
            assign trig_o[k] = trig_of(mode_q[POL_LSB + k], mode_q[1]);
        end else begin : g_edge
            assign trig_o[k] = trig_of(mode_q[POL_LSB + k], 1'b0);
        end
        assign pin_clr_o[k] = req.clr_we && (req.code == PIN_VEC);
    end

    assign nmi_clr_o = req.clr_we && (req.code == NMI_VEC);

    // R2
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en_i && wr_addr_i == MODE_ADDR) |=> $stable(mode_q));

    // R7
    clr_single_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({pin_clr_o, nmi_clr_o}) <= 1);

endmodule

// File: rtl/eirq_pin_cell.sv
module eirq_pin_cell
    import eirq_pkg::*;
#(
    parameter bit LEVEL_OK = 1'b0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  pin_i,
    input  trig_e trig_i,
    input  logic  clr_i,
    output logic  flag_o
);

    trig_e eff_trig;
    logic  prev_q;
    logic  set_w;

    if (LEVEL_OK) begin : g_lvl
        assign eff_trig = trig_i;
    end else begin : g_edge
        assign eff_trig = (trig_i == TRIG_HIGH) ? TRIG_RISE : trig_i;
    end

    assign set_w = trig_hit(eff_trig, prev_q, pin_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            flag_o <= 1'b0;
        end else begin
            prev_q <= pin_i;
            if (set_w)
                flag_o <= 1'b1;
            else if (clr_i)
                flag_o <= 1'b0;
        end
    end

    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_o && !clr_i) |=> flag_o);

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_i && set_w) |=> flag_o);

    // R7
    fall_on_clr_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(flag_o) |-> $past(clr_i));

    // R3
    rise_only_chk: assert property (@(posedge clk) disable iff (rst)
        (trig_i == TRIG_RISE && !flag_o && !(pin_i && !prev_q)) |=> !flag_o);

    // R4
    fall_only_chk: assert property (@(posedge clk) disable iff (rst)
        (trig_i == TRIG_FALL && !flag_o && !(!pin_i && prev_q)) |=> !flag_o);

    // R5
    level_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (LEVEL_OK && trig_i == TRIG_HIGH && pin_i) |=> flag_o);

endmodule

// File: rtl/eirq_nmi_cell.sv
module eirq_nmi_cell
    import eirq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic nmi_i,
    input  logic both_i,
    input  logic clr_i,
    output logic flag_o
);

    logic prev_q;
    logic set_w;

    assign set_w = nmi_hit(both_i, prev_q, nmi_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b1;
            flag_o <= 1'b0;
        end else begin
            prev_q <= nmi_i;
            if (set_w)
                flag_o <= 1'b1;
            else if (clr_i)
                flag_o <= 1'b0;
        end
    end

    // R6
    nmi_fall_set_chk: assert property (@(posedge clk) disable iff (rst)
        (prev_q && !nmi_i) |=> flag_o);

    // R6
    nmi_rise_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (!both_i && !flag_o && !(prev_q && !nmi_i)) |=> !flag_o);

    // R9
    nmi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_o && !clr_i) |=> flag_o);

endmodule

// File: rtl/eirq_detector.sv
module eirq_detector
    import eirq_pkg::*;
#(
    parameter int NUM_PINS = 4,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic                nmi_i,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   wr_addr_i,
    input  logic [DATA_W-1:0]   wr_data_i,
    output logic [NUM_PINS-1:0] req_o,
    output logic                nmi_req_o
);

    trig_e [NUM_PINS-1:0] trig;
    logic  [NUM_PINS-1:0] pin_clr;
    logic                 nmi_both;
    logic                 nmi_clr;

    eirq_cfg #(
        .NUM_PINS (NUM_PINS),
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W)
    ) cfg_i (
        .clk        (clk),
        .rst        (rst),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .trig_o     (trig),
        .nmi_both_o (nmi_both),
        .pin_clr_o  (pin_clr),
        .nmi_clr_o  (nmi_clr)
    );

    for (genvar k = 0; k < NUM_PINS; k++) begin : g_cell
        eirq_pin_cell #(
            .LEVEL_OK (k == 0)
        ) cell_i (
            .clk    (clk),
            .rst    (rst),
            .pin_i  (pin_i[k]),
            .trig_i (trig[k]),
            .clr_i  (pin_clr[k]),
            .flag_o (req_o[k])
        );
    end

    eirq_nmi_cell nmi_i_cell (
        .clk    (clk),
        .rst    (rst),
        .nmi_i  (nmi_i),
        .both_i (nmi_both),
        .clr_i  (nmi_clr),
        .flag_o (nmi_req_o)
    );

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (req_o == '0 && !nmi_req_o));

endmodule

// File: tb/eirq_detector_tb.sv
module eirq_detector_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] pin = 4'h0;
    logic       nmi = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic [3:0] req;
    logic       nmi_req;

    int    tests = 0;
    int    fails = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    always #4 clk = ~clk;

    eirq_detector dut_i (
        .clk       (clk),
        .rst       (rst),
        .pin_i     (pin),
        .nmi_i     (nmi),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .req_o     (req),
        .nmi_req_o (nmi_req)
    );

    // reference model state
    int m_mode = 0;
    int m_flag[5];
    int m_prev[5];

    task automatic check(input string r, input logic [4:0] act, input logic [4:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b at %0t", r, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0;
            foreach (m_flag[i]) m_flag[i] = 0;
            for (int i = 0; i < 4; i++) m_prev[i] = 0;
            m_prev[4] = 1;
        end else begin
            for (int i = 0; i < 5; i++) begin
                int cur;
                int set;
                int code;
                code = (i == 4) ? 2 : 10 + i;
                cur  = (i == 4) ? int'(nmi) : int'(pin[i]);
                if (i == 4)
                    set = (m_prev[i] == 1 && cur == 0) ||
                          ((m_mode & 1) != 0 && m_prev[i] == 0 && cur == 1);
                else if (i == 0 && (m_mode & 2) != 0)
                    set = cur;
                else if ((m_mode >> (2 + i)) & 1)
                    set = (m_prev[i] == 1 && cur == 0);
                else
                    set = (m_prev[i] == 0 && cur == 1);
                if (set)
                    m_flag[i] = 1;
                else if (wr_en && wr_addr == 8'h88 && int'(wr_data % 64) == code)
                    m_flag[i] = 0;
                m_prev[i] = cur;
            end
            if (wr_en && wr_addr == 8'h8C)
                m_mode = int'(wr_data % 64);
        end
        #1;
        if (!done)
            check({cur_req, "-model"}, {nmi_req, req},
                  {m_flag[4][0], m_flag[3][0], m_flag[2][0], m_flag[1][0], m_flag[0][0]});
    end

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        tests++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        tick(3);
        cur_req = "R1";
        check("R1", {nmi_req, req}, 5'b0);
        rst = 1'b0;
        cur_req = "R10";
        tick(3);
        check("R10", {nmi_req, req}, 5'b0);

        cur_req = "R3";
        pin = 4'hF; tick();
        check("R3", {nmi_req, req}, 5'b01111);
        cur_req = "R9";
        pin = 4'h0; tick(2);
        check("R9", {nmi_req, req}, 5'b01111);

        cur_req = "R7";
        wr(8'h88, 8'h0A);
        check("R7", {nmi_req, req}, 5'b01110);
        wr(8'h88, 8'hCB);
        check("R7", {nmi_req, req}, 5'b01100);
        wr(8'h88, 8'h3F);
        check("R7", {nmi_req, req}, 5'b01100);
        wr(8'h89, 8'h0C);
        check("R7", {nmi_req, req}, 5'b01100);
        wr(8'h88, 8'h0C);
        wr(8'h88, 8'h0D);
        check("R7", {nmi_req, req}, 5'b0);

        cur_req = "R4";
        wr(8'h8C, 8'h3C);
        wr(8'h8D, 8'h00);
        pin = 4'hF; tick();
        check("R4", {nmi_req, req}, 5'b0);
        pin = 4'h0; tick();
        check("R4", {nmi_req, req}, 5'b01111);
        cur_req = "R2";
        for (int c = 10; c < 14; c++) wr(8'h88, 8'(c));
        wr(8'h8C, 8'hC0);
        pin = 4'hA; tick();
        check("R2", {nmi_req, req}, 5'b01010);
        pin = 4'h0;
        for (int c = 10; c < 14; c++) wr(8'h88, 8'(c));

        cur_req = "R5";
        wr(8'h8C, 8'h02);
        pin = 4'h1; tick();
        check("R5", {nmi_req, req}, 5'b00001);
        wr(8'h88, 8'h0A);
        check("R5", {nmi_req, req}, 5'b00001);
        pin = 4'h0; tick(2);
        check("R5", {nmi_req, req}, 5'b00001);
        wr(8'h88, 8'h0A);
        check("R5", {nmi_req, req}, 5'b0);

        cur_req = "R8";
        wr_en = 1'b1; wr_addr = 8'h88; wr_data = 8'h0B; pin = 4'h2;
        tick();
        wr_en = 1'b0;
        check("R8", {nmi_req, req}, 5'b00010);
        pin = 4'h0;
        wr(8'h88, 8'h0B);

        cur_req = "R6";
        wr(8'h8C, 8'h00);
        nmi = 1'b0; tick();
        check("R6", {nmi_req, req}, 5'b10000);
        wr(8'h88, 8'h02);
        nmi = 1'b1; tick();
        check("R6", {nmi_req, req}, 5'b0);
        wr(8'h8C, 8'h01);
        nmi = 1'b0; tick();
        check("R6", {nmi_req, req}, 5'b10000);
        wr(8'h88, 8'h02);
        nmi = 1'b1; tick();
        check("R6", {nmi_req, req}, 5'b10000);
        wr(8'h88, 8'h02);

        cur_req = "R9-random";
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = int'($urandom % 16);
            pin = 4'($urandom);
            nmi = 1'($urandom);
            if (r < 5) begin
                wr_en = 1'b1; wr_addr = 8'h88;
                wr_data = {2'($urandom), (r < 4) ? 6'(10 + r) : 6'h02};
            end else if (r == 5) begin
                wr_en = 1'b1; wr_addr = 8'h8C; wr_data = 8'($urandom);
            end else if (r == 6) begin
                wr_en = 1'b1; wr_addr = 8'h88; wr_data = 8'($urandom);
            end else begin
                wr_en = 1'b0;
            end
            tick();
        end
        wr_en = 1'b0;
        tick(2);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule